// File: doc/BRIEF.md
# Serial Receiver with Standby and Wake-Up

This block receives asynchronous serial characters on a single line and hands each one to a parallel output. It runs from a one-cycle sample enable pulsed at sixteen times the bit rate. A character is one low start bit, eight data bits with the least significant bit first, and one high stop bit. A completed character raises a data-ready flag, and a read strobe lowers it. A stop bit that is sampled low sets a framing flag, and the byte is still delivered. An idle flag reports one full character time of high line.

The receiver is meant for a multidrop line on which each message opens with an address. Software reads the address. If the message belongs to another node, software pulses a sleep request, and the receiver enters standby. In standby no character raises the data-ready flag. Hardware leaves standby on one of two wake-up events, picked by a mode input:
- In idle mode, the event is one full character time of high line. That idle character is absorbed and raises no flag.
- In address mode, the event is a character whose eighth data bit is 1. Standby is cleared as soon as that bit is sampled, and the address character itself is delivered.

An idle-start select decides where the count of high bit times begins: either straight after a start bit (so trailing ones of a character count), or only after the stop bit has been sampled.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, dataReady, idleFlag, frameErr and sleeping are 0. While rxEnable is 0, characters and idle time on rxLine change none of the flags.
- R2: A character (start 0, eight data bits with the least significant bit first, stop 1) received while awake loads rxData and sets dataReady by the end of the stop bit. A pulse on dataRead clears dataReady.
- R3: If the stop bit is sampled as 0, frameErr is set and the byte is still loaded with dataReady set. dataRead clears frameErr.
- R4: While awake and enabled, 160 consecutive high sample ticks (ten bit times) on rxLine set idleFlag once. A low sample restarts the count, and dataRead clears idleFlag.
- R5: With idleFromStop = 0, high bits after the start bit count toward idle, so after a 0xFF character idleFlag rises about one bit time after the stop bit. With idleFromStop = 1, the count restarts when the stop bit is sampled, so idleFlag rises about ten bit times after the stop bit.
- R6: A pulse on sleepReq while rxEnable is 1 makes sleeping read 1 on the next clock. While rxEnable is 0, the pulse is ignored.
- R7: While sleeping is 1, received characters neither set dataReady nor change rxData.
- R8: With wakeOnAddr = 0, an idle character while sleeping clears sleeping without setting idleFlag or dataReady. The next character is then delivered.
- R9: With wakeOnAddr = 0, requesting sleep while the line has already been idle for a full character leaves sleeping at 1 for one clock only, then clears it.
- R10: With wakeOnAddr = 1, a character whose eighth data bit is 1 clears sleeping as soon as that bit is sampled, before the stop bit. It then sets dataReady with its byte.
- R11: With wakeOnAddr = 1, idle time and characters whose eighth data bit is 0 leave sleeping at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| rxEnable | input | 1 | Receiver enable |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxLine | input | 1 | Serial input, idles high |
| wakeOnAddr | input | 1 | Wake-up event: 0 idle character, 1 address mark |
| idleFromStop | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| sleepReq | input | 1 | Software pulse that enters standby |
| dataRead | input | 1 | Read strobe; clears dataReady, idleFlag, frameErr |
| rxData | output | 8 | Last delivered byte |
| dataReady | output | 1 | Byte waiting to be read |
| idleFlag | output | 1 | Idle character seen while awake |
| frameErr | output | 1 | Last delivered byte had a low stop bit |
| sleeping | output | 1 | Standby state, readable |

## Verification
The hardest case to reach is entering standby in idle mode without waking at once. The line has to be busy when sleep is requested. The bench therefore sends the request a few clocks into a start bit. By then the low level has restarted the idle count, and the rest of that character, plus a second one, must be swallowed. The early clear in address mode is observed by sampling sleeping a few ticks into the stop bit, while dataReady is still low. The immediate wake in idle mode is observed one and two clocks after a request made on a long-idle line.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

  // Strobes from the control FSM into the datapath.
  typedef struct packed {
    logic shiftBit;   // capture the current line sample as the next data bit
    logic loadData;   // copy the assembled byte into the output register
    logic frameEnd;   // the stop bit is being sampled now
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_t;

endpackage

// File: rtl/uart_wake_dp.sv
module uart_wake_dp
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxEnable,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 idleFromStop,
  input  dpStrobe_t            strobe,
  output logic                 rxBit,
  output logic                 fallEdge,
  output logic                 idleHit,
  output logic                 idleFull,
  output logic [DATA_BITS-1:0] rxData
);

  localparam int IDLE_TICKS = (DATA_BITS + 2) * OVERSAMPLE;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(IDLE_TICKS);
  localparam logic [IDLE_W-1:0] IDLE_NEAR = IDLE_W'(IDLE_TICKS - 1);

  logic                 rxMeta;
  logic                 rxSync;
  logic                 rxPrev;
  logic [DATA_BITS-1:0] shiftReg;
  logic [IDLE_W-1:0]    idleCnt;
  logic                 idleRestart;

  // Two-flop synchroniser; the line rests high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxPrev <= 1'b1;
    else if (sampleTick) rxPrev <= rxSync;
  end

  assign rxBit    = rxSync;
  assign fallEdge = sampleTick && rxPrev && !rxSync;

  // Shift right so the first bit received ends in bit 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxData <= '0;
    else if (strobe.loadData) rxData <= shiftReg;
  end

  // Idle counter: high sample ticks in a row, saturating at one character time.
  assign idleRestart = !rxSync || (strobe.frameEnd && idleFromStop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  idleCnt <= '0;
    else if (!rxEnable)         idleCnt <= '0;
    else if (sampleTick) begin
      if (idleRestart)          idleCnt <= '0;
      else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
    end
  end

  assign idleFull = (idleCnt == IDLE_MAX);
  assign idleHit  = rxEnable && sampleTick && !idleRestart && (idleCnt == IDLE_NEAR);

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && sampleTick && !rxSync |=> !idleFull) else $error("idle count kept across low sample"); // R4

  AST_IDLE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !idleFull && !idleHit |=> !idleFull) else $error("idle full without a hit"); // R4

endmodule

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      sampleTick,
  input  logic      rxBit,
  input  logic      fallEdge,
  input  logic      idleHit,
  input  logic      idleFull,
  input  logic      wakeOnAddr,
  input  logic      sleepReq,
  input  logic      dataRead,
  output dpStrobe_t strobe,
  output logic      dataReady,
  output logic      idleFlag,
  output logic      frameErr,
  output logic      sleeping
);

  localparam int OS_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam logic [OS_W-1:0]  CNT_MID  = OS_W'(OVERSAMPLE / 2 - 2);
  localparam logic [OS_W-1:0]  CNT_LAST = OS_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [OS_W-1:0]  osCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             stepTick;
  logic             bitSample;
  logic             stopSample;
  logic             addrMark;
  logic             idleWake;
  logic             sleepSet;

  assign stepTick   = rxEnable && sampleTick;
  assign bitSample  = stepTick && (state == ST_DATA) && (osCnt == CNT_LAST);
  assign stopSample = stepTick && (state == ST_STOP) && (osCnt == CNT_LAST);
  assign addrMark   = bitSample && (bitCnt == BIT_LAST) && rxBit && wakeOnAddr;
  assign idleWake   = !wakeOnAddr && (idleHit || idleFull);
  assign sleepSet   = rxEnable && sleepReq;

  always_comb begin
    strobe          = '0;
    strobe.shiftBit = bitSample;
    strobe.frameEnd = stopSample;
    strobe.loadData = stopSample && !sleeping;
  end

  // Frame sequencer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      osCnt  <= '0;
      bitCnt <= '0;
    end else if (!rxEnable) begin
      state  <= ST_IDLE;
      osCnt  <= '0;
      bitCnt <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            state <= ST_START;
            osCnt <= '0;
          end
        end
        ST_START: begin
          if (osCnt == CNT_MID) begin
            osCnt  <= '0;
            bitCnt <= '0;
            state  <= rxBit ? ST_IDLE : ST_DATA;
          end else begin
            osCnt <= osCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (osCnt == CNT_LAST) begin
            osCnt  <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == BIT_LAST) state <= ST_STOP;
          end else begin
            osCnt <= osCnt + 1'b1;
          end
        end
        default: begin
          if (osCnt == CNT_LAST) begin
            osCnt <= '0;
            state <= ST_IDLE;
          end else begin
            osCnt <= osCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // Standby: a software request wins over a wake event in the same clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                sleeping <= 1'b0;
    else if (sleepSet)                        sleeping <= 1'b1;
    else if (sleeping && (addrMark || idleWake)) sleeping <= 1'b0;
  end

  // Status flags: a set in the same clock as a read wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      frameErr  <= 1'b0;
      idleFlag  <= 1'b0;
    end else begin
      if (strobe.loadData) begin
        dataReady <= 1'b1;
        frameErr  <= !rxBit;
      end else if (dataRead) begin
        dataReady <= 1'b0;
        frameErr  <= 1'b0;
      end
      if (idleHit && !sleeping) idleFlag <= 1'b1;
      else if (dataRead)        idleFlag <= 1'b0;
    end
  end

  AST_SLEEP_NEXT_CLK: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && sleepReq |=> sleeping) else $error("sleep request lost"); // R6

  AST_SLEEP_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable && !sleeping |=> !sleeping) else $error("sleep entered while disabled"); // R6

  AST_STANDBY_NO_READY: assert property (@(posedge clk) disable iff (!rstN)
    sleeping && !dataReady |=> !dataReady) else $error("byte delivered in standby"); // R7

  AST_WAKE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    sleeping && !wakeOnAddr && !idleFlag |=> !idleFlag) else $error("wake idle raised flag"); // R8

  AST_IDLE_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    sleeping && !wakeOnAddr && idleFull && !sleepSet |=> !sleeping) else $error("idle line did not wake"); // R9

  AST_ADDR_KEEPS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    sleeping && wakeOnAddr && !bitSample |=> sleeping) else $error("left standby without address bit"); // R11

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxEnable,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 wakeOnAddr,
  input  logic                 idleFromStop,
  input  logic                 sleepReq,
  input  logic                 dataRead,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataReady,
  output logic                 idleFlag,
  output logic                 frameErr,
  output logic                 sleeping
);

  dpStrobe_t strobe;
  logic      rxBit;
  logic      fallEdge;
  logic      idleHit;
  logic      idleFull;

  uart_wake_dp #(
    .DATA_BITS (DATA_BITS),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxEnable    (rxEnable),
    .sampleTick  (sampleTick),
    .rxLine      (rxLine),
    .idleFromStop(idleFromStop),
    .strobe      (strobe),
    .rxBit       (rxBit),
    .fallEdge    (fallEdge),
    .idleHit     (idleHit),
    .idleFull    (idleFull),
    .rxData      (rxData)
  );

  uart_wake_ctrl #(
    .DATA_BITS (DATA_BITS),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .sampleTick(sampleTick),
    .rxBit     (rxBit),
    .fallEdge  (fallEdge),
    .idleHit   (idleHit),
    .idleFull  (idleFull),
    .wakeOnAddr(wakeOnAddr),
    .sleepReq  (sleepReq),
    .dataRead  (dataRead),
    .strobe    (strobe),
    .dataReady (dataReady),
    .idleFlag  (idleFlag),
    .frameErr  (frameErr),
    .sleeping  (sleeping)
  );

endmodule

// File: tb/uart_wake_rx_tb.sv
module uart_wake_rx_tb;

  localparam int BIT_CLKS = 32; // 16 ticks, one every other clock

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       wakeOnAddr = 1'b0;
  logic       idleFromStop = 1'b0;
  logic       sleepReq = 1'b0;
  logic       dataRead = 1'b0;
  logic [7:0] rxData;
  logic       dataReady;
  logic       idleFlag;
  logic       frameErr;
  logic       sleeping;

  int checks = 0;
  int errors = 0;
  logic [7:0] lastByte = 8'h00;

  always #2 clk = ~clk;
  always @(negedge clk) sampleTick <= ~sampleTick;

  uart_wake_rx u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .sampleTick(sampleTick),
    .rxLine(rxLine), .wakeOnAddr(wakeOnAddr), .idleFromStop(idleFromStop),
    .sleepReq(sleepReq), .dataRead(dataRead), .rxData(rxData),
    .dataReady(dataReady), .idleFlag(idleFlag), .frameErr(frameErr),
    .sleeping(sleeping)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic v);
    rxLine = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic sendBody(input logic [7:0] b, input logic stopV);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    sendBit(stopV);
    rxLine = 1'b1;
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopV);
    sendBit(1'b0);
    sendBody(b, stopV);
  endtask

  task automatic readPulse();
    dataRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0;
    @(negedge clk);
  endtask

  task automatic sleepPulse();
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 dataReady", dataReady, 0);
    chk("R1 idleFlag", idleFlag, 0);
    chk("R1 frameErr", frameErr, 0);
    chk("R1 sleeping", sleeping, 0);

    // Disabled: traffic and idle time change nothing.
    sendFrame(8'h5A, 1'b1);
    idleBits(12);
    chk("R1 disabled dataReady", dataReady, 0);
    chk("R1 disabled idleFlag", idleFlag, 0);
    sleepPulse();
    @(negedge clk);
    chk("R6 sleep ignored when disabled", sleeping, 0);

    // Enable, then a full idle character sets the idle flag.
    rxEnable = 1'b1;
    idleBits(11);
    chk("R4 idle flag set", idleFlag, 1);
    readPulse();
    chk("R4 idle flag cleared by read", idleFlag, 0);

    // Byte sweep with occasional low stop bits.
    for (int b = 0; b < 256; b += 5) begin
      logic stopV;
      stopV = (b % 3 == 0) ? 1'b0 : 1'b1;
      sendFrame(8'(b), stopV);
      chk("R2 data", rxData, b);
      chk("R2 ready", dataReady, 1);
      chk("R3 frame error", frameErr, stopV ? 0 : 1);
      readPulse();
      chk("R2 ready cleared", dataReady, 0);
      chk("R3 frame error cleared", frameErr, 0);
      lastByte = 8'(b);
      idleBits(2);
    end

    // Idle count start select.
    for (int ilt = 0; ilt < 2; ilt++) begin
      idleFromStop = ilt[0];
      idleBits(12);
      readPulse();
      sendFrame(8'hFF, 1'b1);
      readPulse();
      idleBits(4);
      chk("R5 idle after 4 bits", idleFlag, (ilt == 0) ? 1 : 0);
      idleBits(8);
      chk("R5 idle after 12 bits", idleFlag, 1);
      readPulse();
    end
    lastByte = 8'hFF;
    idleFromStop = 1'b0;

    // Immediate wake on a long-idle line in idle mode.
    wakeOnAddr = 1'b0;
    sleepPulse();
    chk("R6 sleeping next clock", sleeping, 1);
    @(negedge clk);
    chk("R9 immediate wake", sleeping, 0);
    chk("R8 no idle flag on wake", idleFlag, 0);

    // Enter standby during a start bit, so the line is not idle.
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    sleepPulse();
    chk("R6 sleeping set in frame", sleeping, 1);
    repeat (BIT_CLKS - 5) @(negedge clk);
    sendBody(8'h3C, 1'b1);
    chk("R7 no ready in standby", dataReady, 0);
    chk("R7 data unchanged", rxData, lastByte);
    idleBits(2);
    sendFrame(8'h15, 1'b1);
    chk("R7 second frame ignored", dataReady, 0);
    chk("R7 still sleeping", sleeping, 1);
    idleBits(12);
    chk("R8 idle wakes", sleeping, 0);
    chk("R8 wake idle sets no idle flag", idleFlag, 0);
    chk("R8 wake idle sets no ready", dataReady, 0);
    sendFrame(8'h62, 1'b1);
    chk("R8 ready after wake", dataReady, 1);
    chk("R8 data after wake", rxData, 8'h62);
    readPulse();

    // Address-mark mode.
    wakeOnAddr = 1'b1;
    idleBits(12);
    readPulse();
    sleepPulse();
    @(negedge clk);
    chk("R11 no wake on idle line", sleeping, 1);
    idleBits(12);
    chk("R11 idle does not wake", sleeping, 1);
    sendFrame(8'h35, 1'b1);
    chk("R11 data frame keeps standby", sleeping, 1);
    chk("R11 data frame not delivered", dataReady, 0);
    idleBits(2);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(8'hA7 >> i);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 awake before stop", sleeping, 0);
    chk("R10 ready not yet", dataReady, 0);
    repeat (BIT_CLKS - 4) @(negedge clk);
    chk("R10 address delivered", dataReady, 1);
    chk("R10 address data", rxData, 8'hA7);
    readPulse();
    idleBits(2);
    sendFrame(8'h11, 1'b1);
    chk("R10 following data delivered", rxData, 8'h11);
    readPulse();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule